// File: doc/BRIEF.md
# Processor Status Byte with Add/Subtract Flag Logic

This block holds the 8-bit status byte of a small accumulator processor. It also contains the adder that produces the flags. Each cycle it combines two operands and a carry/borrow input under a two-bit operation code, and drives the 8-bit result. When the update strobe is high, it latches carry, nibble carry and signed overflow into the byte.

The parity bit follows the accumulator on every clock edge. Software can replace the whole byte through a write port. Two bank bits in the byte select where the eight working registers sit in direct RAM. The block turns them, together with a 3-bit register number, into a 5-bit RAM address.

Top module: `status_word_reg`

## Requirements
- R1: After reset the status byte reads 00h, so bank 0 is selected and `reg_addr` equals `reg_num`.
- R2: `alu_res` is combinational. For `op_sel` 0 it is opa+opb. For 1 it is opa+opb+cin. For 2 it is opa−opb−cin. For 3 it is opa+opb+cin. All results are modulo 256.
- R3: On an arithmetic update, bit 7 (carry) becomes 1 when an addition carries out of bit 7, or when a subtraction borrows into bit 7. Otherwise it becomes 0.
- R4: On an arithmetic update, bit 6 (nibble carry) follows the same rule as R3, taken between bit 3 and bit 4.
- R5: On an arithmetic update, bit 2 (overflow) is 1 exactly when the signed two's-complement result lies outside −128..+127.
- R6: Bit 0 (parity) is loaded on every clock edge with 1 if `acc` holds an odd number of ones, and 0 if even. This does not depend on the strobe or on a software write.
- R7: `reg_addr` equals bank×8 + `reg_num`, where the bank is status bits 4:3.
- R8: When `sw_we` is high, bits 7..2 load from `sw_wdata[7:2]` on the next edge. This wins over a simultaneous arithmetic update. Bit 1 always reads 0.
- R9: Bit 5 (user flag) and bits 4:3 (bank) change only through software writes, never through arithmetic.
- R10: Without `upd_en`, or with `op_sel` 3, bits 7, 6 and 2 keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand (subtrahend for op 2) |
| cin | input | 1 | Carry in (ops 1, 3) or borrow in (op 2) |
| op_sel | input | 2 | 0 add, 1 add with carry, 2 subtract with borrow, 3 reserved |
| upd_en | input | 1 | Latch arithmetic flags this cycle |
| sw_we | input | 1 | Software write of the status byte |
| sw_wdata | input | 8 | Software write data |
| acc | input | 8 | Current accumulator value |
| reg_num | input | 3 | Working register number 0..7 |
| status_q | output | 8 | Stored status byte |
| alu_res | output | 8 | Arithmetic result |
| reg_addr | output | 5 | Direct RAM address of the selected working register |

## Verification
A wrong flag or bank value is latched in a register, so it appears on `status_q` one edge after the offending stimulus. A corrupted bank also moves `reg_addr` in that same cycle. Because the bench compares the full byte after every edge against a model built from integer arithmetic, an error cannot sit hidden across several cycles. Result errors show on `alu_res` before the edge, since that path holds no state.

// File: rtl/stw_pkg.sv
package stw_pkg;
  localparam int WORD_W = 8;
  localparam int NIB_W  = 4;
  localparam int BANK_W = 2;
  localparam int RIDX_W = 3;
  localparam int ADDR_W = BANK_W + RIDX_W;

  localparam int CY_B  = 7;
  localparam int AC_B  = 6;
  localparam int F0_B  = 5;
  localparam int BKH_B = 4;
  localparam int BKL_B = 3;
  localparam int OV_B  = 2;
  localparam int NU_B  = 1;
  localparam int PAR_B = 0;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_ADDC = 2'd1,
    OP_SUBB = 2'd2,
    OP_RSVD = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic [WORD_W-1:0] res;
    logic              cy;
    logic              ac;
    logic              ov;
  } arith_out_t;

  // Subtraction runs as a + ~b + ~borrow; carry flags are inverted afterwards.
  function automatic arith_out_t arith_eval(input logic [WORD_W-1:0] a,
                                            input logic [WORD_W-1:0] b,
                                            input logic cin,
                                            input alu_op_e op);
    arith_out_t          r;
    logic                sub;
    logic                c0;
    logic [WORD_W-1:0]   be;
    logic [NIB_W:0]      lo;
    logic [WORD_W-1:0]   hi;
    logic [WORD_W:0]     full;
    sub  = (op == OP_SUBB);
    be   = sub ? ~b : b;
    c0   = (op == OP_ADD) ? 1'b0 : (sub ? ~cin : cin);
    lo   = {1'b0, a[NIB_W-1:0]} + {1'b0, be[NIB_W-1:0]} + {{NIB_W{1'b0}}, c0};
    hi   = {1'b0, a[WORD_W-2:0]} + {1'b0, be[WORD_W-2:0]} + {{(WORD_W-1){1'b0}}, c0};
    full = {1'b0, a} + {1'b0, be} + {{WORD_W{1'b0}}, c0};
    r.res = full[WORD_W-1:0];
    r.cy  = full[WORD_W] ^ sub;
    r.ac  = lo[NIB_W] ^ sub;
    r.ov  = hi[WORD_W-1] ^ full[WORD_W];
    return r;
  endfunction

  function automatic logic odd_parity(input logic [WORD_W-1:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/stw_arith.sv
module stw_arith
  import stw_pkg::*;
(
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic              cin,
  input  alu_op_e           op,
  output logic [WORD_W-1:0] res,
  output logic              cy,
  output logic              ac,
  output logic              ov
);
  arith_out_t ao;

  always_comb begin
    ao  = arith_eval(opa, opb, cin, op);
    res = ao.res;
    cy  = ao.cy;
    ac  = ao.ac;
    ov  = ao.ov;
  end
endmodule

// File: rtl/stw_flag_reg.sv
module stw_flag_reg
  import stw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [WORD_W-1:0] sw_data,
  input  logic              flag_load,
  input  logic              cy_in,
  input  logic              ac_in,
  input  logic              ov_in,
  input  logic [WORD_W-1:0] acc,
  output logic [WORD_W-1:0] status_q
);
  logic [WORD_W-1:0] stat_r;
  logic [WORD_W-1:0] stat_d;

  always_comb begin
    stat_d = stat_r;
    if (sw_wr) begin
      stat_d = sw_data;
    end else if (flag_load) begin
      stat_d[CY_B] = cy_in;
      stat_d[AC_B] = ac_in;
      stat_d[OV_B] = ov_in;
    end
    stat_d[NU_B]  = 1'b0;
    stat_d[PAR_B] = odd_parity(acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_r <= '0;
    else        stat_r <= stat_d;
  end

  assign status_q = stat_r;
endmodule

// File: rtl/stw_bank_addr.sv
module stw_bank_addr
  import stw_pkg::*;
(
  input  logic [BANK_W-1:0] bank,
  input  logic [RIDX_W-1:0] reg_num,
  output logic [ADDR_W-1:0] reg_addr
);
  localparam int BANK_SPAN = 1 << RIDX_W;

  always_comb begin
    reg_addr = ADDR_W'(int'(bank) * BANK_SPAN + int'(reg_num));
  end
endmodule

// File: rtl/status_word_reg.sv
module status_word_reg
  import stw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic              cin,
  input  logic [1:0]        op_sel,
  input  logic              upd_en,
  input  logic              sw_we,
  input  logic [WORD_W-1:0] sw_wdata,
  input  logic [WORD_W-1:0] acc,
  input  logic [RIDX_W-1:0] reg_num,
  output logic [WORD_W-1:0] status_q,
  output logic [WORD_W-1:0] alu_res,
  output logic [ADDR_W-1:0] reg_addr
);
  alu_op_e op_e;
  logic    cy_w, ac_w, ov_w;
  logic    sw_wr_evt;
  logic    arith_upd_evt;
  logic    flag_load_evt;

  assign op_e          = alu_op_e'(op_sel);
  assign sw_wr_evt     = sw_we;
  assign arith_upd_evt = upd_en && (op_e != OP_RSVD);
  assign flag_load_evt = arith_upd_evt && !sw_wr_evt;

  stw_arith u_arith (
    .opa (opa),
    .opb (opb),
    .cin (cin),
    .op  (op_e),
    .res (alu_res),
    .cy  (cy_w),
    .ac  (ac_w),
    .ov  (ov_w)
  );

  stw_flag_reg u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_wr     (sw_wr_evt),
    .sw_data   (sw_wdata),
    .flag_load (flag_load_evt),
    .cy_in     (cy_w),
    .ac_in     (ac_w),
    .ov_in     (ov_w),
    .acc       (acc),
    .status_q  (status_q)
  );

  stw_bank_addr u_bank (
    .bank     (status_q[BKH_B:BKL_B]),
    .reg_num  (reg_num),
    .reg_addr (reg_addr)
  );
endmodule

// File: rtl/stw_checker.sv
module stw_checker
  import stw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sw_wr_evt,
  input logic              arith_upd_evt,
  input logic [WORD_W-1:0] sw_wdata,
  input logic [WORD_W-1:0] acc,
  input logic [RIDX_W-1:0] reg_num,
  input logic [WORD_W-1:0] status_q,
  input logic [ADDR_W-1:0] reg_addr
);
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[NU_B] == 1'b0);                                           // R8

  AST_PARITY_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status_q[PAR_B] == ^$past(acc));                          // R6

  AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_evt |=> status_q[WORD_W-1:OV_B] == $past(sw_wdata[WORD_W-1:OV_B])); // R8

  AST_ARITH_KEEPS_USER: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_evt |=> $stable(status_q[F0_B:BKL_B]));                     // R9

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_evt && !arith_upd_evt) |=> $stable(status_q[WORD_W-1:NU_B])); // R10

  AST_ADDR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr[RIDX_W-1:0] == reg_num);                                  // R7
endmodule

bind status_word_reg stw_checker chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .sw_wr_evt     (sw_wr_evt),
  .arith_upd_evt (arith_upd_evt),
  .sw_wdata      (sw_wdata),
  .acc           (acc),
  .reg_num       (reg_num),
  .status_q      (status_q),
  .reg_addr      (reg_addr)
);

// File: tb/status_word_reg_tb.sv
`timescale 1ns/1ps
module status_word_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] opa = '0, opb = '0, sw_wdata = '0, acc = '0;
  logic       cin = 1'b0, upd_en = 1'b0, sw_we = 1'b0;
  logic [1:0] op_sel = '0;
  logic [2:0] reg_num = '0;
  logic [7:0] status_q, alu_res;
  logic [4:0] reg_addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int model_st = 0;

  always #2 clk = ~clk;

  status_word_reg dut_i (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .cin(cin),
    .op_sel(op_sel), .upd_en(upd_en), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .acc(acc), .reg_num(reg_num), .status_q(status_q), .alu_res(alu_res),
    .reg_addr(reg_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  task automatic step(input int a, input int b, input int c, input int op,
                      input int up, input int we, input int wd, input int av,
                      input int rn);
    int res, cyf, acf, ovf, s, so, ce;
    opa = a[7:0]; opb = b[7:0]; cin = c[0]; op_sel = op[1:0];
    upd_en = up[0]; sw_we = we[0]; sw_wdata = wd[7:0]; acc = av[7:0];
    reg_num = rn[2:0];
    if (op == 2) begin
      s   = a - b - c;
      cyf = (s < 0) ? 1 : 0;
      acf = ((a % 16) - (b % 16) - c < 0) ? 1 : 0;
      so  = sgn(a) - sgn(b) - c;
    end else begin
      ce  = (op == 0) ? 0 : c;
      s   = a + b + ce;
      cyf = (s > 255) ? 1 : 0;
      acf = ((a % 16) + (b % 16) + ce > 15) ? 1 : 0;
      so  = sgn(a) + sgn(b) + ce;
    end
    res = (s + 512) % 256;
    ovf = (so < -128 || so > 127) ? 1 : 0;
    #1;
    chk("R2 result", alu_res, res);
    @(posedge clk);
    if (we != 0) begin
      model_st = (model_st % 4) + (wd / 4) * 4;
    end else if (up != 0 && op != 3) begin
      model_st = model_st - (model_st & 8'hC4) + cyf * 128 + acf * 64 + ovf * 4;
    end
    model_st = model_st - (model_st % 2) + (ones(av) % 2);
    model_st = model_st - (model_st & 2);
    @(negedge clk);
    chk("R3 carry", status_q[7], (model_st >> 7) & 1);
    chk("R4 nibble carry", status_q[6], (model_st >> 6) & 1);
    chk("R5 overflow", status_q[2], (model_st >> 2) & 1);
    chk("R6 parity", status_q[0], model_st & 1);
    chk("R9 user flag and bank", status_q[5:3], (model_st >> 3) & 7);
    chk("R8 unused bit", status_q[1], 0);
    chk("R7 reg addr", reg_addr, ((model_st >> 3) & 3) * 8 + rn);
    chk("R10 whole byte", status_q, model_st);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    reg_num = 3'd5;
    repeat (3) @(negedge clk);
    chk("R1 reset status", status_q, 0);
    chk("R1 reset addr", reg_addr, 5);
    rst_n = 1'b1;
    @(negedge clk);
    // Directed corners
    step(8'h7F, 8'h01, 0, 0, 1, 0, 0, 8'h01, 0);   // R5 overflow, R4 AC
    step(8'hFF, 8'h01, 0, 0, 1, 0, 0, 8'h03, 1);   // R3 carry out
    step(8'h00, 8'h01, 0, 2, 1, 0, 0, 8'h07, 2);   // R3 borrow
    step(8'h80, 8'h01, 0, 2, 1, 0, 0, 8'h00, 3);   // R5 signed underflow
    step(8'h10, 8'h00, 1, 2, 1, 0, 0, 8'hFF, 4);   // R4 nibble borrow
    step(8'h0F, 8'h00, 1, 1, 1, 0, 0, 8'h80, 5);   // R4 carry with cin
    step(8'hFF, 8'hFF, 1, 3, 1, 0, 0, 8'h11, 6);   // R10 reserved op
    step(8'hFF, 8'hFF, 1, 1, 0, 0, 0, 8'h11, 7);   // R10 no strobe
    step(8'hFF, 8'h01, 0, 0, 1, 1, 8'h3B, 8'h01, 2); // R8 sw write wins
    step(8'h00, 8'h00, 0, 0, 1, 0, 0, 8'h00, 7);   // R9 arith clears flags only
    step(8'h12, 8'h34, 0, 0, 0, 1, 8'hFF, 8'h55, 1); // R8 bank 3, bit1 zero
    step(8'h00, 8'h00, 0, 0, 0, 1, 8'h08, 8'h01, 6); // R7 bank 1
    step(8'h00, 8'h00, 0, 0, 0, 1, 8'h10, 8'h01, 6); // R7 bank 2
    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 1),
           $urandom_range(0, 3), ($urandom_range(0, 3) != 0) ? 1 : 0,
           ($urandom_range(0, 7) == 0) ? 1 : 0, $urandom_range(0, 255),
           $urandom_range(0, 255), $urandom_range(0, 7));
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule